// File: doc/BRIEF.md
# Masked Packed Unsigned Multiply-High Unit

This block is a SIMD datapath that cuts two 512-bit source vectors into 16-bit unsigned lanes. It multiplies each pair of matching lanes into a full 32-bit product and keeps only the upper half. A length code sets how many lanes are active: 4, 8, 16 or 32, which is a vector of 64, 128, 256 or 512 bits. An optional per-lane write mask decides, for each active lane, whether that lane takes the product. A lane that is masked off is either zeroed or keeps its old destination value.

Destination bits above the active length depend on a legacy-mode input. With legacy mode set, those bits keep the old destination value. With legacy mode clear, they are driven to zero. The old destination arrives as an input, so the caller can feed either source back in as the destination, as the two-operand form needs.

The result is registered. It appears together with an output valid flag one clock cycle after the input valid strobe. The register holds its value while no new request arrives.

Top module: `pmulhu_mask_unit`

## Requirements
- R1: Each active lane that takes the product outputs bits 31:16 of the unsigned 32-bit product of its two 16-bit source lanes. For example, 0xFFFF times 0xFFFF gives 0xFFFE, and any lane with a zero operand gives 0x0000.
- R2: The length code sets the active lane count: 2'b00 gives 4 lanes (64 bits), 2'b01 gives 8 lanes, 2'b10 gives 16 lanes and 2'b11 gives 32 lanes. Lane i occupies bits 16i+15 down to 16i.
- R3: With legacy_i low, every lane at or above the active lane count outputs 0x0000.
- R4: With legacy_i high, every lane at or above the active lane count outputs the matching bits of dst_old_i.
- R5: With mask_en_i low, every active lane takes the product, whatever the value of mask_i.
- R6: With mask_en_i high, an active lane i whose mask_i[i] is 1 takes the product.
- R7: With mask_en_i high and zero_i high, an active lane whose mask bit is 0 outputs 0x0000.
- R8: With mask_en_i high and zero_i low, an active lane whose mask bit is 0 outputs its dst_old_i lane.
- R9: Mask bits at or above the active lane count have no effect on result_o.
- R10: valid_o is high in exactly the cycle after a cycle with valid_i high, and result_o then carries that request's result. While valid_i is low, result_o holds its last value.
- R11: While reset is asserted, valid_o is 0 and result_o is all zero.
- R12: Exchanging src_a_i and src_b_i does not change result_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe; loads the result register |
| len_i | input | 2 | Vector length code |
| legacy_i | input | 1 | 1: keep old bits above the length; 0: clear them |
| mask_en_i | input | 1 | Enables per-lane write masking |
| zero_i | input | 1 | With masking: 1 zeroes masked-off lanes, 0 merges them |
| mask_i | input | 32 | Per-lane write mask, bit i for lane i |
| src_a_i | input | 512 | First source vector |
| src_b_i | input | 512 | Second source vector |
| dst_old_i | input | 512 | Old destination value |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| result_o | output | 512 | Registered result vector |

## Verification
Every request gives its result exactly one clock edge after the edge that samples valid_i, and valid_o rises at that same edge. The driver applies inputs on the falling edge and pushes the expected vector into a queue. The monitor samples a quarter period after each rising edge and pops one expected item for each cycle in which valid_o is high. Hold behaviour is checked by idling valid_i with changed inputs for two cycles and confirming that result_o has not moved.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
  localparam int unsigned LANE_W    = 16;
  localparam int unsigned MAX_LANES = 32;
  localparam int unsigned MIN_LANES = 4;
  localparam int unsigned VEC_W     = LANE_W * MAX_LANES;
  localparam int unsigned LEN_W     = 2;
  localparam int unsigned CNT_W     = $clog2(MAX_LANES) + 1;

  typedef enum logic [LEN_W-1:0] {
    VL_64  = 2'b00,
    VL_128 = 2'b01,
    VL_256 = 2'b10,
    VL_512 = 2'b11
  } vlen_e;

  typedef enum logic [1:0] {
    SRC_PROD = 2'b00,
    SRC_OLD  = 2'b01,
    SRC_ZERO = 2'b10
  } lane_src_e;
endpackage

// File: rtl/pmh_lane_mul.sv
module pmh_lane_mul #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] a_ext;
  logic [PW-1:0] b_ext;

  assign a_ext = {{W{1'b0}}, a_i};
  assign b_ext = {{W{1'b0}}, b_i};
  // upper half of the full-width unsigned product
  assign hi_o  = W'((a_ext * b_ext) >> W);
endmodule

// File: rtl/pmh_len_decode.sv
module pmh_len_decode
  import pmh_pkg::*;
#(
  parameter int unsigned LANES = MAX_LANES,
  parameter int unsigned BASE  = MIN_LANES
) (
  input  logic [LEN_W-1:0] len_i,
  output logic [LANES-1:0] active_o
);
  localparam int unsigned CW = $clog2(LANES) + 1;

  logic [CW-1:0] lane_cnt;

  always_comb begin
    unique case (vlen_e'(len_i))
      VL_64:   lane_cnt = CW'(BASE);
      VL_128:  lane_cnt = CW'(BASE << 1);
      VL_256:  lane_cnt = CW'(BASE << 2);
      default: lane_cnt = CW'(BASE << 3);
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_act
    assign active_o[g] = (CW'(g) < lane_cnt);
  end
endmodule

// File: rtl/pmh_lane_ctl.sv
module pmh_lane_ctl
  import pmh_pkg::*;
#(
  parameter int unsigned W = LANE_W
) (
  input  logic         active_i,
  input  logic         legacy_i,
  input  logic         mask_en_i,
  input  logic         mask_bit_i,
  input  logic         zero_i,
  input  logic [W-1:0] prod_hi_i,
  input  logic [W-1:0] old_i,
  output logic [W-1:0] lane_o
);
  lane_src_e src_sel;

  always_comb begin
    if (!active_i) begin
      src_sel = legacy_i ? SRC_OLD : SRC_ZERO;
    end else if (mask_en_i && !mask_bit_i) begin
      src_sel = zero_i ? SRC_ZERO : SRC_OLD;
    end else begin
      src_sel = SRC_PROD;
    end
  end

  always_comb begin
    unique case (src_sel)
      SRC_PROD: lane_o = prod_hi_i;
      SRC_OLD:  lane_o = old_i;
      default:  lane_o = '0;
    endcase
  end
endmodule

// File: rtl/pmulhu_mask_unit.sv
module pmulhu_mask_unit
  import pmh_pkg::*;
#(
  parameter int unsigned LW = LANE_W,
  parameter int unsigned NL = MAX_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             legacy_i,
  input  logic             mask_en_i,
  input  logic             zero_i,
  input  logic [NL-1:0]    mask_i,
  input  logic [NL*LW-1:0] src_a_i,
  input  logic [NL*LW-1:0] src_b_i,
  input  logic [NL*LW-1:0] dst_old_i,
  output logic             valid_o,
  output logic [NL*LW-1:0] result_o
);
  localparam int unsigned VW = NL * LW;

  logic [NL-1:0] lane_active;
  logic [VW-1:0] lane_res;
  logic [VW-1:0] res_d;
  logic [VW-1:0] res_q;
  logic          vld_d;
  logic          vld_q;

  pmh_len_decode #(
    .LANES (NL),
    .BASE  (MIN_LANES)
  ) u_len (
    .len_i    (len_i),
    .active_o (lane_active)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LW-1:0] hi;

    pmh_lane_mul #(.W(LW)) u_mul (
      .a_i  (src_a_i[g*LW +: LW]),
      .b_i  (src_b_i[g*LW +: LW]),
      .hi_o (hi)
    );

    pmh_lane_ctl #(.W(LW)) u_ctl (
      .active_i   (lane_active[g]),
      .legacy_i   (legacy_i),
      .mask_en_i  (mask_en_i),
      .mask_bit_i (mask_i[g]),
      .zero_i     (zero_i),
      .prod_hi_i  (hi),
      .old_i      (dst_old_i[g*LW +: LW]),
      .lane_o     (lane_res[g*LW +: LW])
    );
  end

  // next-state
  always_comb begin
    vld_d = valid_i;
    res_d = res_q;
    if (valid_i) begin
      res_d = lane_res;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign valid_o  = vld_q;
  assign result_o = res_q;
endmodule

// File: rtl/pmh_mask_unit_chk.sv
module pmh_mask_unit_chk
  import pmh_pkg::*;
#(
  parameter int unsigned LW = LANE_W,
  parameter int unsigned NL = MAX_LANES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic [LEN_W-1:0] len_i,
  input logic             legacy_i,
  input logic             mask_en_i,
  input logic             zero_i,
  input logic [NL-1:0]    mask_i,
  input logic [NL*LW-1:0] src_a_i,
  input logic [NL*LW-1:0] src_b_i,
  input logic [NL*LW-1:0] dst_old_i,
  input logic             valid_o,
  input logic [NL*LW-1:0] result_o
);
  localparam int unsigned VW = NL * LW;
  localparam int unsigned B4 = MIN_LANES * LW;

  // R10: output valid follows a request by one cycle
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);

  // R10: no output valid without a request
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);

  // R10: result held while idle
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(result_o));

  // R3: shortest length, non-legacy, upper bits cleared
  a_r3_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !legacy_i && len_i == VL_64) |=> (result_o[VW-1:B4] == '0));

  // R4: shortest length, legacy, upper bits kept from old destination
  a_r4_upper_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && legacy_i && len_i == VL_64) |=>
      (result_o[VW-1:B4] == $past(dst_old_i[VW-1:B4])));

  // R7: full mask clear with zeroing at full length gives all zero
  a_r7_all_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_en_i && zero_i && mask_i == '0 && len_i == VL_512)
      |=> (result_o == '0));

  // R1: zero operand in lane 0 with no masking gives zero
  a_r1_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !mask_en_i && (src_a_i[LW-1:0] == '0 || src_b_i[LW-1:0] == '0))
      |=> (result_o[LW-1:0] == '0));

  // R11: reset state
  a_r11_reset_state: assert property (@(posedge clk)
    !rst_n |-> (!valid_o && result_o == '0));
endmodule

bind pmulhu_mask_unit pmh_mask_unit_chk #(.LW(LW), .NL(NL)) u_chk (.*);

// File: tb/pmulhu_mask_unit_tb.sv
module pmulhu_mask_unit_tb;
  localparam int NL = 32;
  localparam int LW = 16;
  localparam int VW = NL * LW;

  typedef struct {
    logic [VW-1:0] res;
    string         tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          valid_i;
  logic [1:0]    len_i;
  logic          legacy_i;
  logic          mask_en_i;
  logic          zero_i;
  logic [NL-1:0] mask_i;
  logic [VW-1:0] src_a_i;
  logic [VW-1:0] src_b_i;
  logic [VW-1:0] dst_old_i;
  logic          valid_o;
  logic [VW-1:0] result_o;

  int checks;
  int errors;
  logic [31:0] seed;
  logic [VW-1:0] last_exp;
  exp_t sb[$];

  pmulhu_mask_unit u_dut (
    .clk (clk), .rst_n (rst_n), .valid_i (valid_i), .len_i (len_i),
    .legacy_i (legacy_i), .mask_en_i (mask_en_i), .zero_i (zero_i),
    .mask_i (mask_i), .src_a_i (src_a_i), .src_b_i (src_b_i),
    .dst_old_i (dst_old_i), .valid_o (valid_o), .result_o (result_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [VW-1:0] model(
    input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] old,
    input logic [NL-1:0] m, input logic [1:0] len, input logic leg,
    input logic men, input logic z);
    logic [VW-1:0] r;
    int act;
    act = 4 << len;
    r = '0;
    for (int i = 0; i < NL; i++) begin
      logic [31:0] p;
      p = 32'(a[i*LW +: LW]) * 32'(b[i*LW +: LW]);
      if (i >= act)          r[i*LW +: LW] = leg ? old[i*LW +: LW] : 16'h0;
      else if (men && !m[i]) r[i*LW +: LW] = z ? 16'h0 : old[i*LW +: LW];
      else                   r[i*LW +: LW] = p[31:16];
    end
    return r;
  endfunction

  task automatic gen(output logic [VW-1:0] v);
    for (int k = 0; k < VW / 32; k++) begin
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      v[k*32 +: 32] = seed;
    end
  endtask

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [VW-1:0] old, input logic [NL-1:0] m,
                       input logic [1:0] len, input logic leg, input logic men,
                       input logic z, input string tag);
    exp_t e;
    @(negedge clk);
    src_a_i = a; src_b_i = b; dst_old_i = old; mask_i = m; len_i = len;
    legacy_i = leg; mask_en_i = men; zero_i = z; valid_i = 1'b1;
    e.res = model(a, b, old, m, len, leg, men, z);
    e.tag = tag;
    last_exp = e.res;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #5;
    if (rst_n && valid_o) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10: actual valid_o=1 expected 0 (no pending request)");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, result_o, e.res);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] a, b, o, r1, r2;
    checks = 0; errors = 0; seed = 32'h1234_5678;
    rst_n = 1'b0; valid_i = 1'b0; len_i = 2'b11; legacy_i = 1'b0;
    mask_en_i = 1'b0; zero_i = 1'b0; mask_i = '0;
    src_a_i = '0; src_b_i = '0; dst_old_i = '0;
    repeat (3) @(posedge clk);
    #5;
    check("R11 reset valid", {{(VW-1){1'b0}}, valid_o}, '0);
    check("R11 reset result", result_o, '0);
    @(negedge clk); rst_n = 1'b1;

    // R1 corner values
    drive({NL{16'hFFFF}}, {NL{16'hFFFF}}, '0, '0, 2'b11, 1'b0, 1'b0, 1'b0, "R1 ffff*ffff");
    gen(a);
    drive(a, '0, {NL{16'hAAAA}}, '0, 2'b11, 1'b0, 1'b0, 1'b0, "R1 zero operand");
    drive({NL{16'h8000}}, {NL{16'h0002}}, '0, '0, 2'b11, 1'b0, 1'b0, 1'b0, "R1 8000*2");

    // R2 R3 R4 every length, both legacy settings
    for (int l = 0; l < 4; l++) begin
      gen(a); gen(b); gen(o);
      drive(a, b, o, '0, 2'(l), 1'b0, 1'b0, 1'b0, "R2 R3 length non-legacy");
      gen(a); gen(b); gen(o);
      drive(a, b, o, '0, 2'(l), 1'b1, 1'b0, 1'b0, "R2 R4 length legacy");
    end

    // R5 mask ignored when disabled
    gen(a); gen(b); gen(o);
    drive(a, b, o, 32'h0F0F_3C21, 2'b11, 1'b0, 1'b0, 1'b1, "R5 mask disabled");
    // R6 R7 mask zeroing
    gen(a); gen(b); gen(o);
    drive(a, b, o, 32'hA5A5_5A5A, 2'b11, 1'b0, 1'b1, 1'b1, "R6 R7 mask zeroing");
    // R6 R8 mask merge
    gen(a); gen(b); gen(o);
    drive(a, b, o, 32'h1357_9BDF, 2'b10, 1'b0, 1'b1, 1'b0, "R6 R8 mask merge");
    drive(a, b, o, '0, 2'b11, 1'b0, 1'b1, 1'b1, "R7 all lanes zeroed");
    idle();
    repeat (3) @(negedge clk);

    // R9 upper mask bits ignored: compare two requests directly as well
    gen(a); gen(b); gen(o);
    drive(a, b, o, 32'h0000_00C5, 2'b01, 1'b0, 1'b1, 1'b0, "R9 upper mask clear");
    idle(); @(posedge clk); #5; r1 = result_o;
    drive(a, b, o, 32'hFFFF_FFC5, 2'b01, 1'b0, 1'b1, 1'b0, "R9 upper mask set");
    idle(); @(posedge clk); #5; r2 = result_o;
    check("R9 upper mask bits no effect", r2, r1);

    // R12 symmetry
    gen(a); gen(b); gen(o);
    drive(a, b, o, 32'h6C6C_3939, 2'b11, 1'b1, 1'b1, 1'b0, "R12 a,b order");
    idle(); @(posedge clk); #5; r1 = result_o;
    drive(b, a, o, 32'h6C6C_3939, 2'b11, 1'b1, 1'b1, 1'b0, "R12 b,a order");
    idle(); @(posedge clk); #5; r2 = result_o;
    check("R12 swap sources", r2, r1);

    // R10 back-to-back then hold
    for (int n = 0; n < 6; n++) begin
      gen(a); gen(b); gen(o);
      drive(a, b, o, seed, 2'(n), 1'(n), 1'(n >> 1), 1'(n >> 2), "R10 back-to-back");
    end
    @(negedge clk);
    valid_i = 1'b0;
    gen(src_a_i); gen(src_b_i); gen(dst_old_i); mask_i = '1; len_i = 2'b11;
    @(posedge clk); #5;
    @(posedge clk); #5;
    check("R10 idle valid_o low", {{(VW-1){1'b0}}, valid_o}, '0);
    check("R10 result held", result_o, last_exp);

    repeat (3) @(posedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R10: actual %0d pending results expected 0", sb.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule